// File: doc/BRIEF.md
# HDLC Bit-Stuffing Frame Transmitter

This block turns packets taken from a byte-wide source into a single-bit HDLC line stream, one line bit per clock. Each packet goes out between an opening and a closing flag, followed by a 16-bit frame check sequence. A zero is inserted after any five ones in the packet body or the check sequence, so that no content can be mistaken for a flag, an abort or idle fill. Bytes are pulled through a valid/ready handshake whose end-of-packet marker ends the packet.

When no packet is pending, the line carries either an unbroken run of flags or constant ones, chosen by a mode input. A request input cuts the current frame short with an abort pattern. If the source has no byte ready when one is due, the frame is aborted the same way. An enable input and a synchronous software reset both force the line to the marking (one) level and return the block to its waiting state.

Top module: `hdlc_tx_framer`

## Requirements
- R1: With `tx_en` high, `fill_ones` low and no packet pending, `line_bit` carries back-to-back flags. The flag is byte 0x7E sent least significant bit first, i.e. the line sequence 0,1,1,1,1,1,1,0, repeated with no gap.
- R2: With `tx_en` high, `fill_ones` high and no packet pending, `line_bit` stays at 1 for as long as the state lasts (at least 15 bit times in any such stretch).
- R3: A byte offered on `in_valid` ends the wait state. In flag fill mode this happens only once the flag in progress is complete; in ones mode it happens at once. One opening flag follows, then each byte least significant bit first. Bytes are taken when `in_valid` and `in_ready` are both high at a clock edge.
- R4: In the body and check sequence, a 0 is inserted after every five consecutive 1 bits. Stuffed zeros also restart the count. Flags, abort patterns and fill are never stuffed.
- R5: The check sequence is CRC-16 with polynomial x^16+x^12+x^5+1, computed LSB-first (reflected constant 0x8408) with a preset of 0xFFFF. It is sent ones-complemented, low-order bit first. Running the same CRC over the de-stuffed body plus check sequence gives residue 0xF0B8.
- R6: Zero insertion applies up to and including the last five bits of the check sequence. When those bits are all ones, a stuffed zero precedes the closing flag.
- R7: A closing flag follows the check sequence, and the block then returns to the selected wait state.
- R8: `abort_req` high at a clock edge while a frame is in its opening flag, body or check sequence replaces the rest of that frame with a 0 followed by seven 1s. The block then returns to the wait state. Bytes not yet taken stay with the source.
- R9: If a byte is due (end of the opening flag, or end of a non-final byte) and `in_valid` is low, the frame is aborted as in R8.
- R10: `tx_en` low, or `soft_rst` high, at a clock edge sets `line_bit` to 1 from the next cycle, drops `in_ready`, and returns the block to the wait state, with fill starting on a fresh flag.
- R11: While `rst_n` is low, `line_bit` is 1 and `in_ready` is 0.
- R12: `in_ready` is high only in the single bit time in which a byte is due, so each byte is taken exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one line bit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset |
| tx_en | input | 1 | Transmitter enable |
| fill_ones | input | 1 | Wait-state select: 0 flags, 1 constant ones |
| abort_req | input | 1 | Abort the frame in progress |
| in_data | input | BYTE_W | Byte from the source |
| in_valid | input | 1 | Source byte present |
| in_last | input | 1 | Byte is the last of its packet |
| in_ready | output | 1 | Byte taken at this edge when valid |
| line_bit | output | 1 | Serial line output |

## Verification
Frames of mixed bytes are sent in both fill modes. A receiver model in the bench strips stuffed zeros, locates flags and checks the CRC residue. This separates a correct frame from errors in bit order, flag placement and check sequence. An all-ones payload forces repeated stuffing in the body. A payload whose check sequence ends in five ones is found by search in the bench, which exercises stuffing before the closing flag. All-zero payloads cut short by a request, by a source underrun, by disable and by software reset make the abort bit position exact. They also show that the wait state resumes cleanly afterwards.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

   typedef enum logic [2:0] {
      ST_WAIT,
      ST_OPEN,
      ST_DATA,
      ST_FCS,
      ST_CLOSE,
      ST_ABORT
   } tx_state_e;

   // Flag pattern as a byte; bit 0 leaves first on the line.
   localparam logic [7:0] FLAG_PAT = 8'h7E;

endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen #(
   parameter int          W        = 16,
   parameter logic [15:0] POLY_REV = 16'h8408,
   parameter logic [15:0] PRESET   = 16'hFFFF
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         en,
   input  logic         din,
   output logic [W-1:0] crc_q,
   output logic [W-1:0] crc_nxt
);

   localparam logic [W-1:0] POLY = POLY_REV[W-1:0];
   localparam logic [W-1:0] INIT = PRESET[W-1:0];

   if (W < 8 || W > 16) begin : g_bad_width
      $error("hdlc_fcs_gen: W must lie in 8..16");
   end

   logic fb;
   assign fb = crc_q[0] ^ din;

   // Shift-right register: each stage takes its upper neighbour, tapped by the polynomial.
   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == W - 1) begin : g_top
         assign crc_nxt[i] = POLY[i] & fb;
      end else begin : g_mid
         assign crc_nxt[i] = crc_q[i+1] ^ (POLY[i] & fb);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= INIT;
      else if (clr) crc_q <= INIT;
      else if (en)  crc_q <= crc_nxt;
   end

endmodule

// File: rtl/hdlc_zero_ins.sv
module hdlc_zero_ins #(
   parameter int RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic bit_valid,
   input  logic bit_val,
   input  logic countable,
   output logic stuff_now
);

   localparam int CNT_W = $clog2(RUN + 1);

   if (RUN < 1 || RUN > 5) begin : g_bad_run
      $error("hdlc_zero_ins: RUN must lie in 1..5");
   end

   logic [CNT_W-1:0] ones_q;

   assign stuff_now = (ones_q == CNT_W'(RUN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       ones_q <= '0;
      else if (clr)                     ones_q <= '0;
      else if (bit_valid) begin
         if (!countable || !bit_val)    ones_q <= '0;
         else                           ones_q <= ones_q + 1'b1;
      end
   end

   // R4
   run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= CNT_W'(RUN));

   // R4
   stuff_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stuff_now && bit_valid && !clr) |=> (ones_q == '0));

endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer
   import hdlc_tx_pkg::*;
#(
   parameter int          BYTE_W     = 8,
   parameter int          FCS_W      = 16,
   parameter logic [15:0] FCS_POLY   = 16'h8408,
   parameter logic [15:0] FCS_PRESET = 16'hFFFF,
   parameter int          STUFF_RUN  = 5,
   parameter int          ABORT_ONES = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              tx_en,
   input  logic              fill_ones,
   input  logic              abort_req,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_valid,
   input  logic              in_last,
   output logic              in_ready,
   output logic              line_bit
);

   localparam int SPAN_A = (FCS_W > BYTE_W) ? FCS_W : BYTE_W;
   localparam int SPAN_B = (ABORT_ONES + 1 > 8) ? ABORT_ONES + 1 : 8;
   localparam int SPAN   = (SPAN_A > SPAN_B) ? SPAN_A : SPAN_B;
   localparam int IDX_W  = $clog2(SPAN);

   localparam logic [IDX_W-1:0] BYTE_END  = IDX_W'(BYTE_W - 1);
   localparam logic [IDX_W-1:0] FCS_END   = IDX_W'(FCS_W - 1);
   localparam logic [IDX_W-1:0] FLAG_END  = IDX_W'(7);
   localparam logic [IDX_W-1:0] ABORT_END = IDX_W'(ABORT_ONES);

   if (BYTE_W < 2) begin : g_bad_byte
      $error("hdlc_tx_framer: BYTE_W must be at least 2");
   end
   if (ABORT_ONES < STUFF_RUN + 2) begin : g_bad_abort
      $error("hdlc_tx_framer: abort run must exceed the flag's ones");
   end

   tx_state_e         st_q;
   logic [IDX_W-1:0]  idx_q;
   logic [2:0]        fill_q;
   logic [BYTE_W-1:0] sr_q;
   logic              last_q;
   logic [FCS_W-1:0]  fcs_q;
   logic              line_q;

   logic              stuff;
   logic              raw_bit;
   logic              cur_bit;
   logic              adv;
   logic              abortable;
   logic              need_byte;
   logic              countable;
   logic [FCS_W-1:0]  crc_q;
   logic [FCS_W-1:0]  crc_nxt;

   // ---------------- bit selection ----------------
   always_comb begin
      unique case (st_q)
         ST_WAIT:  raw_bit = fill_ones ? 1'b1 : FLAG_PAT[fill_q];
         ST_OPEN,
         ST_CLOSE: raw_bit = FLAG_PAT[idx_q[2:0]];
         ST_DATA:  raw_bit = sr_q[0];
         ST_FCS:   raw_bit = fcs_q[0];
         ST_ABORT: raw_bit = (idx_q != '0);
         default:  raw_bit = 1'b1;
      endcase
   end

   assign cur_bit   = !tx_en ? 1'b1 : (stuff ? 1'b0 : raw_bit);
   assign adv       = tx_en && !stuff;
   assign abortable = (st_q == ST_OPEN) || (st_q == ST_DATA) || (st_q == ST_FCS);
   assign countable = (st_q == ST_DATA) || (st_q == ST_FCS);
   assign need_byte = adv && (idx_q == BYTE_END) &&
                      ((st_q == ST_OPEN && idx_q == FLAG_END) ||
                       (st_q == ST_DATA && !last_q));
   assign in_ready  = need_byte && !abort_req && !soft_rst;
   assign line_bit  = line_q;

   // ---------------- sub-blocks ----------------
   hdlc_zero_ins #(
      .RUN (STUFF_RUN)
   ) u_zins (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr       (soft_rst || !tx_en),
      .bit_valid (tx_en),
      .bit_val   (cur_bit),
      .countable (countable),
      .stuff_now (stuff)
   );

   hdlc_fcs_gen #(
      .W        (FCS_W),
      .POLY_REV (FCS_POLY),
      .PRESET   (FCS_PRESET)
   ) u_fcs (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (st_q == ST_WAIT || st_q == ST_OPEN),
      .en      (adv && st_q == ST_DATA),
      .din     (sr_q[0]),
      .crc_q   (crc_q),
      .crc_nxt (crc_nxt)
   );

   // ---------------- sequencer ----------------
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_WAIT;
         idx_q  <= '0;
         fill_q <= '0;
         sr_q   <= '0;
         last_q <= 1'b0;
         fcs_q  <= '0;
         line_q <= 1'b1;
      end else if (soft_rst || !tx_en) begin
         st_q   <= ST_WAIT;
         idx_q  <= '0;
         fill_q <= '0;
         last_q <= 1'b0;
         line_q <= 1'b1;
      end else begin
         line_q <= cur_bit;
         if (abort_req && abortable) begin
            st_q  <= ST_ABORT;
            idx_q <= '0;
         end else if (adv) begin
            unique case (st_q)
               ST_WAIT: begin
                  if (fill_ones) begin
                     fill_q <= '0;
                     if (in_valid) begin
                        st_q  <= ST_OPEN;
                        idx_q <= '0;
                     end
                  end else begin
                     fill_q <= fill_q + 3'd1;
                     if (fill_q == 3'd7 && in_valid) begin
                        st_q  <= ST_OPEN;
                        idx_q <= '0;
                     end
                  end
               end
               ST_OPEN: begin
                  idx_q <= idx_q + 1'b1;
                  if (idx_q == FLAG_END) begin
                     idx_q <= '0;
                     if (in_valid) begin
                        st_q   <= ST_DATA;
                        sr_q   <= in_data;
                        last_q <= in_last;
                     end else begin
                        st_q <= ST_ABORT;
                     end
                  end
               end
               ST_DATA: begin
                  sr_q  <= sr_q >> 1;
                  idx_q <= idx_q + 1'b1;
                  if (idx_q == BYTE_END) begin
                     idx_q <= '0;
                     if (last_q) begin
                        st_q  <= ST_FCS;
                        fcs_q <= ~crc_nxt;
                     end else if (in_valid) begin
                        sr_q   <= in_data;
                        last_q <= in_last;
                     end else begin
                        st_q <= ST_ABORT;
                     end
                  end
               end
               ST_FCS: begin
                  fcs_q <= fcs_q >> 1;
                  idx_q <= idx_q + 1'b1;
                  if (idx_q == FCS_END) begin
                     st_q  <= ST_CLOSE;
                     idx_q <= '0;
                  end
               end
               ST_CLOSE: begin
                  idx_q <= idx_q + 1'b1;
                  if (idx_q == FLAG_END) begin
                     st_q   <= ST_WAIT;
                     idx_q  <= '0;
                     fill_q <= '0;
                  end
               end
               ST_ABORT: begin
                  idx_q <= idx_q + 1'b1;
                  if (idx_q == ABORT_END) begin
                     st_q   <= ST_WAIT;
                     idx_q  <= '0;
                     fill_q <= '0;
                  end
               end
               default: st_q <= ST_WAIT;
            endcase
         end
      end
   end

   // ---------------- assertions ----------------
   // R2
   ones_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !soft_rst && st_q == ST_WAIT && fill_ones) |=> line_bit);

   // R8
   abort_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !soft_rst && st_q == ST_ABORT && idx_q == '0 && !stuff) |=> !line_bit);

   // R8
   abort_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && !soft_rst && st_q == ST_ABORT && idx_q != '0) |=> line_bit);

   // R10
   disabled_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_en || soft_rst) |=> (line_bit && st_q == ST_WAIT));

   // R12
   ready_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (tx_en && (st_q == ST_OPEN || st_q == ST_DATA)));

   // R3
   take_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (st_q == ST_DATA && idx_q == '0));

   // R4
   open_unstuffed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && st_q == ST_OPEN) |-> !stuff);

endmodule

// File: tb/hdlc_tx_framer_test.sv
`timescale 1ns/1ps
module hdlc_tx_framer_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic       tx_en = 1'b0;
   logic       fill_ones = 1'b0;
   logic       abort_req = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_valid = 1'b0;
   logic       in_last = 1'b0;
   logic       in_ready;
   logic       line_bit;

   hdlc_tx_framer uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .tx_en     (tx_en),
      .fill_ones (fill_ones),
      .abort_req (abort_req),
      .in_data   (in_data),
      .in_valid  (in_valid),
      .in_last   (in_last),
      .in_ready  (in_ready),
      .line_bit  (line_bit)
   );

   always #2.5 clk = ~clk;

   int         n_chk = 0;
   int         n_fail = 0;
   bit         done = 0;
   bit         cap [0:2047];
   int         cap_n = 0;
   bit         cap_on = 0;
   int         hs_cnt = 0;
   bit         kill = 0;
   logic [7:0] pkt [0:15];

   bit         p_found, p_closed, p_abort;
   int         p_open_end, p_len, p_stuffs, p_end, p_run;
   logic [7:0] p_bytes [0:15];
   logic [15:0] p_res;

   always @(posedge clk) if (in_valid && in_ready) hs_cnt <= hs_cnt + 1;

   always @(negedge clk) begin
      if (cap_on && cap_n < 2048) begin
         cap[cap_n] = line_bit;
         cap_n++;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_upd(input logic [15:0] c, input bit b);
      logic fb;
      fb = c[0] ^ b;
      c = c >> 1;
      if (fb) c = c ^ 16'h8408;
      return c;
   endfunction

   function automatic bit is_flag(input int a);
      if (a < 0 || a + 7 >= cap_n) return 0;
      return !cap[a] && cap[a+1] && cap[a+2] && cap[a+3] && cap[a+4] &&
             cap[a+5] && cap[a+6] && !cap[a+7];
   endfunction

   task automatic cap_start();
      cap_n = 0;
      cap_on = 1;
   endtask

   // Receiver model: locate opening flag, strip stuffing, find close or abort.
   task automatic parse();
      bit pay [0:2047];
      int i, k, j, ones, L;
      bit b;
      p_found = 0; p_closed = 0; p_abort = 0; p_stuffs = 0; p_len = 0;
      p_res = 16'hFFFF; p_end = 0; p_run = 0; p_open_end = 0;
      i = -1;
      for (int a = 0; a + 7 < cap_n; a++) begin
         if (is_flag(a)) begin i = a; break; end
      end
      if (i < 0) return;
      p_found = 1;
      k = i;
      while (is_flag(k + 8)) k += 8;
      p_open_end = k + 8;
      j = k + 8; ones = 0; L = 0;
      while (j < cap_n) begin
         b = cap[j];
         if (ones == 5 && !b) begin
            p_stuffs++; ones = 0;
         end else if (b) begin
            ones++; pay[L] = 1'b1; L++;
            if (ones == 7) begin p_abort = 1; p_run = j - 6; break; end
         end else if (ones == 6) begin
            p_closed = 1; L = (L >= 7) ? L - 7 : 0; p_end = j + 1; break;
         end else begin
            ones = 0; pay[L] = 1'b0; L++;
         end
         j++;
      end
      p_len = L;
      for (int q = 0; q < L / 8 && q < 16; q++) begin
         for (int t = 0; t < 8; t++) p_bytes[q][t] = pay[q*8 + t];
      end
      for (int q = 0; q < L; q++) p_res = crc_upd(p_res, pay[q]);
   endtask

   task automatic drive(input int n, input bit mark_last, input int lim, output int sent);
      int c0, w;
      sent = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (kill) break;
         in_data = pkt[i]; in_last = mark_last && (i == n - 1); in_valid = 1'b1;
         c0 = hs_cnt; w = 0;
         while (hs_cnt == c0 && w < lim && !kill) begin
            @(negedge clk); w++;
         end
         if (hs_cnt == c0) break;
         sent++;
      end
      in_valid = 1'b0; in_last = 1'b0;
   endtask

   task automatic run_frame(input string req, input int n, input bit ones_mode);
      int sent, h0, bad;
      fill_ones = ones_mode;
      repeat (12) @(negedge clk);
      cap_start();
      h0 = hs_cnt;
      drive(n, 1'b1, 40, sent);
      repeat (70) @(negedge clk);
      cap_on = 0;
      parse();
      check(p_found && p_closed, req, "frame opened and closed", {p_found, p_closed}, 3);
      check(p_len == (n + 2) * 8, req, "de-stuffed length", p_len, (n + 2) * 8);
      check(p_res == 16'hF0B8, "R5", "check sequence residue", p_res, 16'hF0B8);
      bad = 0;
      for (int q = 0; q < n; q++) if (p_bytes[q] !== pkt[q]) bad++;
      check(bad == 0, "R3", "payload bytes match", bad, 0);
      // R12: one handshake per byte
      check(hs_cnt - h0 == n, "R12", "bytes taken", hs_cnt - h0, n);
      if (ones_mode) begin
         bad = 0;
         for (int q = p_end; q < p_end + 10 && q < cap_n; q++) if (!cap[q]) bad++;
         // R7: back to ones fill after closing flag
         check(bad == 0 && p_end + 10 <= cap_n, "R7", "ones after close", bad, 0);
      end else begin
         // R7: back to flag fill after closing flag
         check(is_flag(p_end), "R7", "flag after close", is_flag(p_end), 1);
      end
   endtask

   task automatic t_reset();
      tx_en = 1'b1;
      repeat (3) @(negedge clk);
      // R11
      check(line_bit === 1'b1 && in_ready === 1'b0, "R11", "reset outputs",
            {line_bit, in_ready}, 2'b10);
      @(negedge clk); rst_n = 1'b1;
   endtask

   task automatic t_flag_fill();
      int i, bad;
      fill_ones = 1'b0;
      repeat (5) @(negedge clk);
      cap_start(); bad = 0;
      repeat (40) begin
         @(negedge clk);
         if (in_ready !== 1'b0) bad++;
      end
      cap_on = 0;
      i = -1;
      for (int a = 0; a < 8; a++) if (is_flag(a)) begin i = a; break; end
      // R1
      check(i >= 0 && is_flag(i+8) && is_flag(i+16) && is_flag(i+24), "R1",
            "unbroken flag fill", i, 0);
      // R12
      check(bad == 0, "R12", "ready low during fill", bad, 0);
   endtask

   task automatic t_ones_fill();
      int bad;
      fill_ones = 1'b1;
      repeat (3) @(negedge clk);
      cap_start();
      repeat (20) @(negedge clk);
      cap_on = 0; bad = 0;
      for (int q = 0; q < cap_n; q++) if (!cap[q]) bad++;
      // R2
      check(bad == 0 && cap_n >= 15, "R2", "constant ones fill", bad, 0);
   endtask

   task automatic t_fcs_stuff();
      logic [15:0] c;
      int found;
      found = -1;
      for (int b = 0; b < 256; b++) begin
         logic [7:0] d1;
         d1 = 8'(b);
         c = 16'hFFFF;
         for (int t = 0; t < 8; t++) c = crc_upd(c, 8'hA5 >> t);
         for (int t = 0; t < 8; t++) c = crc_upd(c, d1[t]);
         if ((~c) >> 11 == 16'h1F) begin found = b; break; end
      end
      check(found >= 0, "R6", "candidate found", found, 0);
      pkt[0] = 8'hA5; pkt[1] = 8'(found);
      run_frame("R6", 2, 1'b1);
      // R6: stuffed zero before the closing flag
      check(p_stuffs >= 1, "R6", "stuff count", p_stuffs, 1);
   endtask

   task automatic t_abort();
      int sent, bad;
      fill_ones = 1'b1;
      for (int q = 0; q < 6; q++) pkt[q] = 8'h00;
      repeat (10) @(negedge clk);
      cap_start();
      fork
         drive(6, 1'b1, 20, sent);
         begin
            repeat (30) @(negedge clk);
            abort_req = 1'b1; kill = 1'b1;
            @(negedge clk);
            abort_req = 1'b0;
         end
      join
      repeat (40) @(negedge clk);
      cap_on = 0; kill = 0;
      parse();
      // R8
      check(p_found && p_abort && !p_closed, "R8", "abort seen", {p_abort, p_closed}, 2);
      bad = 0;
      for (int q = p_open_end; q < p_run; q++) if (cap[q]) bad++;
      check(bad == 0 && p_run > p_open_end, "R8", "zero before abort run", bad, 0);
      bad = 0;
      for (int q = p_run + 7; q < p_run + 22 && q < cap_n; q++) if (!cap[q]) bad++;
      check(bad == 0 && p_run + 22 <= cap_n, "R8", "idle resumes after abort", bad, 0);
   endtask

   task automatic t_underrun();
      int sent;
      fill_ones = 1'b1;
      pkt[0] = 8'h00; pkt[1] = 8'h00;
      repeat (10) @(negedge clk);
      cap_start();
      drive(2, 1'b0, 30, sent);
      repeat (40) @(negedge clk);
      cap_on = 0;
      parse();
      // R9
      check(p_abort && !p_closed, "R9", "underrun aborts", {p_abort, p_closed}, 2);
      check(p_run - p_open_end == 17, "R9", "abort position", p_run - p_open_end, 17);
   endtask

   task automatic t_disable();
      int sent, bad;
      fill_ones = 1'b1;
      for (int q = 0; q < 8; q++) pkt[q] = 8'h00;
      repeat (5) @(negedge clk);
      fork
         drive(8, 1'b1, 100, sent);
         begin
            repeat (15) @(negedge clk);
            tx_en = 1'b0; kill = 1'b1;
         end
      join
      bad = 0;
      repeat (10) begin
         @(negedge clk);
         if (line_bit !== 1'b1 || in_ready !== 1'b0) bad++;
      end
      // R10
      check(bad == 0, "R10", "disabled line marks", bad, 0);
      kill = 0; tx_en = 1'b1;
      pkt[0] = 8'h3C; pkt[1] = 8'hC3;
      run_frame("R10", 2, 1'b1);
   endtask

   task automatic t_softrst();
      int sent, i;
      fill_ones = 1'b0;
      for (int q = 0; q < 8; q++) pkt[q] = 8'h55;
      repeat (5) @(negedge clk);
      fork
         drive(8, 1'b1, 100, sent);
         begin
            repeat (20) @(negedge clk);
            soft_rst = 1'b1; kill = 1'b1;
            @(negedge clk);
            // R10
            check(line_bit === 1'b1 && in_ready === 1'b0, "R10", "soft reset marks",
                  {line_bit, in_ready}, 2'b10);
            soft_rst = 1'b0;
         end
      join
      kill = 0;
      cap_start();
      repeat (30) @(negedge clk);
      cap_on = 0;
      i = -1;
      for (int a = 0; a < 8; a++) if (is_flag(a)) begin i = a; break; end
      check(i >= 0 && is_flag(i + 8), "R10", "flag fill after soft reset", i, 0);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      t_reset();
      t_flag_fill();
      t_ones_fill();
      pkt[0] = 8'h12; pkt[1] = 8'h34; pkt[2] = 8'h56;
      run_frame("R3", 3, 1'b0);
      pkt[0] = 8'h81; pkt[1] = 8'h7E; pkt[2] = 8'hE7; pkt[3] = 8'h0F;
      run_frame("R3", 4, 1'b1);
      for (int q = 0; q < 4; q++) pkt[q] = 8'hFF;
      run_frame("R4", 4, 1'b1);
      // R4: 32 ones in the body need at least six inserted zeros
      check(p_stuffs >= 6, "R4", "body stuff count", p_stuffs, 6);
      t_fcs_stuff();
      t_abort();
      t_underrun();
      t_disable();
      t_softrst();
      done = 1;
      finish_run();
   end

   initial begin
      #(5.0 * 100000);
      if (!done) begin
         check(1'b0, "WDOG", "run timed out", 0, 1);
         finish_run();
      end
   end

endmodule